// File: doc/BRIEF.md
# Wakeup Reason Capture Logic

This block keeps a sticky record of why the device came back from an attempt to enter a low-power state. It watches a set of peripheral wake requests, each gated by its own enable bit, plus two single-cycle pulses. The first pulse marks an entry that was halted because a non-volatile memory or life-cycle transaction was still busy (abort). The second marks an entry that was broken because an interrupt pulled the core out of wait-for-interrupt (fall-through). Each qualifying event is ORed into one bit of an 8-bit info value. Software reads that value and clears bits by writing ones.

Capture is armed by the pulse that marks the start of a valid low-power entry. Once armed, capture stays live across the return to the active state, so several reasons can pile up. It stops only when software sets the capture-disable input. After that, it waits for the next entry pulse to arm again.

Top module: `wake_cause_recorder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `wake_info` reads 0 and capture is disarmed.
- R2: Before any entry-start pulse, wake requests, abort pulses and fall-through pulses leave `wake_info` unchanged.
- R3: Once armed, a wake request `wake_req[i]` that is high while `wake_en[i]` is 1 sets `wake_info[i]` (bits 5:0) on the next clock edge.
- R4: A wake request whose `wake_en` bit is 0 never sets its `wake_info` bit.
- R5: Once armed, an `abort_pulse` sets `wake_info[7]` and a `fallthru_pulse` sets `wake_info[6]` on the next clock edge.
- R6: Recorded bits are sticky. They stay set after the cause goes away, and new reasons are ORed in beside them.
- R7: While `cap_dis` is 1, no bit is set. Setting `cap_dis` also disarms capture, so capture stays off after `cap_dis` returns to 0 until a new entry-start pulse arrives.
- R8: Capture stays armed with no further entry pulse, including long idle spans after reasons were recorded, until `cap_dis` is set.
- R9: When `clr_we` is 1, every `wake_info` bit with a 1 in `clr_data` (same bit positions) is cleared on the next edge. The other bits are kept.
- R10: If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R11: An entry-start pulse with `cap_dis` at 0 captures reasons that are present in the same cycle. An entry-start pulse with `cap_dis` at 1 does not arm capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 6 | Peripheral wake requests, levels |
| wake_en | input | 6 | Per-request wake enable mask |
| entry_start | input | 1 | One-cycle pulse: a valid low-power entry has begun |
| abort_pulse | input | 1 | One-cycle pulse: entry halted by a busy memory or life-cycle transaction |
| fallthru_pulse | input | 1 | One-cycle pulse: entry broken by an interrupt leaving wait-for-interrupt |
| cap_dis | input | 1 | Capture disable from software; 1 suppresses and disarms capture |
| clr_we | input | 1 | Software write strobe for the write-1-to-clear access |
| clr_data | input | 8 | Write data: ones select the bits to clear |
| wake_info | output | 8 | Bit 7 abort, bit 6 fall-through, bits 5:0 peripheral reasons |

## Verification
The bench builds the block with its default of six wake sources, which gives the 8-bit info layout, so all three field groups and their bit positions are exercised. The bench drives the edges of the arming window directly. These include an entry pulse coinciding with a request, an entry pulse while disabled, and re-enable without a new entry. It also drives collisions between a write-1-to-clear and a hardware set on the same bit. A behavioural model is compared every cycle, alongside fixed expected values at each step.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_LIVE = 1'b1
  } arm_state_e;
endpackage

// File: rtl/wcr_arm_ctrl.sv
module wcr_arm_ctrl
  import wcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic entry_start,
  input  logic cap_dis,
  output logic capture_en
);
  arm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cap_dis) begin
      state_d = ARM_IDLE;
    end else if (entry_start) begin
      state_d = ARM_LIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARM_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // A reason present in the entry cycle itself is taken as well.
  assign capture_en = ((state_q == ARM_LIVE) || entry_start) && !cap_dis;
endmodule

// File: rtl/wcr_qualify.sv
module wcr_qualify #(
  parameter int NUM_WAKE = 6,
  localparam int INFO_W  = NUM_WAKE + 2
) (
  input  logic                capture_en,
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                abort_pulse,
  input  logic                fallthru_pulse,
  output logic [INFO_W-1:0]   set_vec
);
  logic [INFO_W-1:0] raw_vec;

  always_comb begin
    raw_vec = {abort_pulse, fallthru_pulse, wake_req & wake_en};
    set_vec = capture_en ? raw_vec : '0;
  end
endmodule

// File: rtl/wcr_sticky_bit.sv
module wcr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic upd_en;

  // Set dominates clear.
  always_comb begin
    upd_en = set_i | clr_i;
    q_d    = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (upd_en) begin
      q_o <= q_d;
    end
  end
endmodule

// File: rtl/wake_cause_recorder.sv
module wake_cause_recorder #(
  parameter int NUM_WAKE = 6,
  localparam int INFO_W  = NUM_WAKE + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WAKE-1:0] wake_req,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                entry_start,
  input  logic                abort_pulse,
  input  logic                fallthru_pulse,
  input  logic                cap_dis,
  input  logic                clr_we,
  input  logic [INFO_W-1:0]   clr_data,
  output logic [INFO_W-1:0]   wake_info
);
  logic              capture_en;
  logic [INFO_W-1:0] set_vec;
  logic [INFO_W-1:0] clr_vec;

  wcr_arm_ctrl u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_start (entry_start),
    .cap_dis     (cap_dis),
    .capture_en  (capture_en)
  );

  wcr_qualify #(.NUM_WAKE(NUM_WAKE)) u_qual (
    .capture_en     (capture_en),
    .wake_req       (wake_req),
    .wake_en        (wake_en),
    .abort_pulse    (abort_pulse),
    .fallthru_pulse (fallthru_pulse),
    .set_vec        (set_vec)
  );

  assign clr_vec = clr_we ? clr_data : '0;

  for (genvar gi = 0; gi < INFO_W; gi++) begin : g_bit
    wcr_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[gi]),
      .clr_i (clr_vec[gi]),
      .q_o   (wake_info[gi])
    );
  end
endmodule

// File: rtl/wcr_checker.sv
module wcr_checker #(
  parameter int NUM_WAKE = 6,
  localparam int INFO_W  = NUM_WAKE + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_WAKE-1:0] wake_req,
  input logic [NUM_WAKE-1:0] wake_en,
  input logic                entry_start,
  input logic                abort_pulse,
  input logic                fallthru_pulse,
  input logic                cap_dis,
  input logic                clr_we,
  input logic [INFO_W-1:0]   clr_data,
  input logic [INFO_W-1:0]   wake_info
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (wake_info == '0);
    end
  end

  assert_enable_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((wake_info[NUM_WAKE-1:0] & ~$past(wake_info[NUM_WAKE-1:0]))
               & ~$past(wake_en)) == '0);

  assert_entry_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_start && !cap_dis && ((wake_req & wake_en) != '0))
    |=> ((wake_info[NUM_WAKE-1:0] & $past(wake_req & wake_en)) == $past(wake_req & wake_en)));

  assert_abort_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_start && !cap_dis && abort_pulse) |=> wake_info[INFO_W-1]);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((wake_info & $past(wake_info)) == $past(wake_info)));

  assert_disable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_dis && !clr_we) |=> (wake_info == $past(wake_info)));

  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && cap_dis) |=> ((wake_info & $past(clr_data)) == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_data[INFO_W-2] && fallthru_pulse && entry_start && !cap_dis)
    |=> wake_info[INFO_W-2]);
endmodule

bind wake_cause_recorder wcr_checker #(.NUM_WAKE(NUM_WAKE)) u_wcr_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .wake_req       (wake_req),
  .wake_en        (wake_en),
  .entry_start    (entry_start),
  .abort_pulse    (abort_pulse),
  .fallthru_pulse (fallthru_pulse),
  .cap_dis        (cap_dis),
  .clr_we         (clr_we),
  .clr_data       (clr_data),
  .wake_info      (wake_info)
);

// File: tb/sim_wake_cause_recorder.sv
`timescale 1ns/1ps
module sim_wake_cause_recorder;
  localparam int NW = 6;
  localparam int IW = NW + 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] wake_req, wake_en;
  logic          entry_start, abort_pulse, fallthru_pulse, cap_dis, clr_we;
  logic [IW-1:0] clr_data;
  logic [IW-1:0] wake_info;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Behavioural reference state
  bit            m_armed;
  logic [IW-1:0] m_info;
  string         tag = "R1";

  always #10 clk = ~clk;

  wake_cause_recorder #(.NUM_WAKE(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .wake_en(wake_en),
    .entry_start(entry_start), .abort_pulse(abort_pulse),
    .fallthru_pulse(fallthru_pulse), .cap_dis(cap_dis), .clr_we(clr_we),
    .clr_data(clr_data), .wake_info(wake_info)
  );

  task automatic check(input string req, input logic [IW-1:0] act, input logic [IW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s wake_info=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wake_req = '0; entry_start = 0; abort_pulse = 0; fallthru_pulse = 0;
    clr_we = 0; clr_data = '0;
  endtask

  // One clock: update the model from the inputs held across the edge,
  // then compare away from the edge and return inputs to idle.
  task automatic tick();
    bit            live;
    logic [IW-1:0] setv;
    @(posedge clk);
    live = (m_armed || entry_start) && !cap_dis;
    setv = live ? {abort_pulse, fallthru_pulse, wake_req & wake_en} : '0;
    if (clr_we) m_info = m_info & ~clr_data;
    m_info = m_info | setv;
    if (cap_dis) m_armed = 0;
    else if (entry_start) m_armed = 1;
    #3;
    check(tag, wake_info, m_info);
    idle_inputs();
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired wake_info=%02h expected=done", wake_info);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cap_dis = 0; wake_en = '0; idle_inputs();
    m_armed = 0; m_info = '0;
    repeat (3) @(negedge clk);
    check("R1", wake_info, 8'h00);
    rst_n = 1;
    tag = "R1"; tick();
    check("R1", wake_info, 8'h00);

    // R2: nothing is recorded before arming
    tag = "R2"; wake_en = 6'h3F; wake_req = 6'h3F; abort_pulse = 1; fallthru_pulse = 1; tick();
    check("R2", wake_info, 8'h00);

    // R3: arm, then an enabled request
    tag = "R3"; entry_start = 1; tick();
    wake_en = 6'h04; wake_req = 6'h04; tick();
    check("R3", wake_info, 8'h04);

    // R4: masked request ignored
    tag = "R4"; wake_req = 6'h3B; tick();
    check("R4", wake_info, 8'h04);

    // R5: abort and fall-through positions
    tag = "R5"; abort_pulse = 1; tick();
    check("R5", wake_info, 8'h84);
    fallthru_pulse = 1; tick();
    check("R5", wake_info, 8'hC4);

    // R6: sticky and accumulating
    tag = "R6"; tick(); tick();
    check("R6", wake_info, 8'hC4);
    wake_en = 6'h20; wake_req = 6'h20; tick();
    check("R6", wake_info, 8'hE4);

    // R9: write-1-to-clear selects bits
    tag = "R9"; clr_we = 1; clr_data = 8'h80; tick();
    check("R9", wake_info, 8'h64);

    // R10: set beats clear on the same bit
    tag = "R10"; wake_en = 6'h02; wake_req = 6'h02; clr_we = 1; clr_data = 8'h02; tick();
    check("R10", wake_info, 8'h66);

    // R7: disable suppresses and disarms
    tag = "R7"; cap_dis = 1; abort_pulse = 1; tick();
    check("R7", wake_info, 8'h66);
    cap_dis = 0; tick();
    abort_pulse = 1; fallthru_pulse = 1; wake_en = 6'h3F; wake_req = 6'h01; tick();
    check("R7", wake_info, 8'h66);

    // R11: entry while disabled does not arm; same-cycle capture on entry
    tag = "R11"; clr_we = 1; clr_data = 8'hFF; tick();
    check("R11", wake_info, 8'h00);
    cap_dis = 1; entry_start = 1; tick();
    cap_dis = 0; abort_pulse = 1; tick();
    check("R11", wake_info, 8'h00);
    entry_start = 1; wake_req = 6'h08; tick();
    check("R11", wake_info, 8'h08);

    // R8: stays armed through idle time
    tag = "R8"; clr_we = 1; clr_data = 8'hFF; tick();
    repeat (20) tick();
    fallthru_pulse = 1; tick();
    check("R8", wake_info, 8'h40);

    // R10 again on an armed entry cycle with clear of bit 6
    tag = "R10"; entry_start = 1; fallthru_pulse = 1; clr_we = 1; clr_data = 8'h40; tick();
    check("R10", wake_info, 8'h40);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule